// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block carries out two cache maintenance operations for a write-back data cache: write-back-then-invalidate and invalidate-only. Each operation targets a single line. The caller presents the operation code, the result of the tag lookup for that line, the line index and the line's contents. The sequencer then holds `busy` high for a fixed number of penalty cycles, which depends on the case. It issues a single invalidate strobe that clears the line's valid and dirty bits. When a dirty line must be written back, it pushes the line into a write-back buffer.

Penalty cycles are counted beyond the one cycle in which the operation is issued. Most cases have a fixed cost. The dirty write-back case has a fixed cost of three cycles plus a variable wait, which covers every cycle in which the write-back buffer reports full. At the end of every operation the block raises `done` for one cycle. In that cycle `stallCount` reports the penalty cycles the operation actually took, and it keeps that value until the next operation is accepted.

The tag array, the write-back buffer's drain to memory and the instruction decode are outside this block. They connect through the lookup inputs, the invalidate strobe and the push/full pair.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset, `busy`, `done`, `invEn` and `wbPush` are low and `stallCount` is 0.
- R2: A write-back-invalidate (`opCode`=0) on a miss (`lookup`=2'b00) costs 0 penalty cycles. `busy` never rises, `done` pulses in the cycle after acceptance, and there is no invalidate and no push.
- R3: A write-back-invalidate on a clean hit (`lookup`=2'b01) holds `busy` for 3 cycles. It raises `invEn` once, in the first busy cycle, with `invIndex` equal to the accepted index. It makes no push.
- R4: A write-back-invalidate on a dirty hit (`lookup`=2'b10) with the buffer not full holds `busy` for 3 cycles. It pushes once, with `wbAddr`/`wbData` equal to the accepted index/line, and raises `invEn` in the same cycle.
- R5: In the dirty case, each cycle in which `wbFull` is high delays the push by one cycle and adds one penalty cycle, so the total is 3+n. No push happens while `wbFull` is high.
- R6: An invalidate-only operation (`opCode`=1) on a miss costs 0 penalty cycles and makes no invalidate and no push.
- R7: An invalidate-only operation on any hit (`lookup` 2'b01, 2'b10 or 2'b11) holds `busy` for 2 cycles. It raises `invEn` once and never pushes, even when the line is dirty.
- R8: While `busy` is high, `opValid` is ignored: no further operation is started and no extra `done` appears.
- R9: `done` is high for exactly one cycle per accepted operation. In that cycle `busy` is low, so a new operation can be accepted in the `done` cycle.
- R10: In that cycle `stallCount` equals the operation's penalty cycle count (0, 2, 3 or 3+n). `lookup`=2'b11 is treated as a dirty hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request; accepted when `busy` is low |
| opCode | input | 1 | 0 = write-back-invalidate, 1 = invalidate-only |
| lookup | input | 2 | 00 miss, 01 clean hit, 10 dirty hit, 11 dirty hit |
| opIndex | input | 8 | Line index of the target line |
| opLine | input | 256 | Contents of the target line (32 bytes) |
| wbFull | input | 1 | Write-back buffer cannot take a line |
| busy | output | 1 | Penalty period in progress |
| done | output | 1 | One-cycle completion pulse |
| stallCount | output | 8 | Penalty cycles of the last operation (saturating) |
| invEn | output | 1 | Clear valid and dirty bits of `invIndex` |
| invIndex | output | 8 | Index of the line to invalidate |
| wbPush | output | 1 | Push one line into the write-back buffer |
| wbAddr | output | 8 | Index of the pushed line |
| wbData | output | 256 | Contents of the pushed line |

## Verification
A wrong penalty counter or state shows up at the ports within a few cycles. The `busy` period comes out too short or too long, `done` arrives early or late, and the `stallCount` reported with `done` disagrees with the busy cycles counted at the ports. A sequencer stuck in the drain wait, or one that ignores `wbFull`, shows as a push during a full cycle or as no `done` at all. A lost or duplicated invalidate pending flag shows in the next operation's invalidate count. An operation accepted while busy shows as an unexpected `done` that has no scoreboard entry.

// File: rtl/cache_maint_pkg.sv
package cache_maint_pkg;

  typedef enum logic {
    OP_WB_INV   = 1'b0,
    OP_INV_ONLY = 1'b1
  } maintOp_e;

  typedef enum logic [1:0] {
    LK_MISS      = 2'b00,
    LK_CLEAN     = 2'b01,
    LK_DIRTY     = 2'b10,
    LK_DIRTY_ALT = 2'b11
  } lookup_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_PENALTY
  } seqState_e;

  // penalty cycles beyond the issue cycle
  localparam int unsigned CLEAN_PENALTY       = 3;
  localparam int unsigned DIRTY_FIXED_PENALTY = 3;
  localparam int unsigned INV_PENALTY         = 2;
  localparam int unsigned CNT_W               = 2;

  typedef struct packed {
    logic             capture;
    logic             cntLoad;
    logic [CNT_W-1:0] cntInit;
    logic             cntDec;
    logic             stallClr;
    logic             stallInc;
    logic             push;
    logic             inv;
    logic             finish;
  } seqStrobe_t;

endpackage

// File: rtl/cache_maint_ctl.sv
module cache_maint_ctl
  import cache_maint_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       opCode,
  input  logic [1:0] lookup,
  input  logic       wbFull,
  input  logic       cntZero,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_e stateQ, stateD;
  logic      invPendQ, invPendD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      invPendQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      invPendQ <= invPendD;
    end
  end

  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    invPendD = invPendQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (opValid) begin
          strobe.capture  = 1'b1;
          strobe.stallClr = 1'b1;
          if (lookup == LK_MISS) begin
            strobe.finish = 1'b1;
          end else if (opCode == OP_INV_ONLY) begin
            strobe.cntLoad = 1'b1;
            strobe.cntInit = CNT_W'(INV_PENALTY - 1);
            invPendD       = 1'b1;
            stateD         = ST_PENALTY;
          end else if (lookup == LK_CLEAN) begin
            strobe.cntLoad = 1'b1;
            strobe.cntInit = CNT_W'(CLEAN_PENALTY - 1);
            invPendD       = 1'b1;
            stateD         = ST_PENALTY;
          end else begin
            stateD = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        strobe.stallInc = 1'b1;
        if (!wbFull) begin
          strobe.push    = 1'b1;
          strobe.inv     = 1'b1;
          strobe.cntLoad = 1'b1;
          strobe.cntInit = CNT_W'(DIRTY_FIXED_PENALTY - 2);
          stateD         = ST_PENALTY;
        end
      end
      ST_PENALTY: begin
        strobe.stallInc = 1'b1;
        strobe.inv      = invPendQ;
        invPendD        = 1'b0;
        if (cntZero) begin
          strobe.finish = 1'b1;
          stateD        = ST_IDLE;
        end else begin
          strobe.cntDec = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/cache_maint_dp.sv
module cache_maint_dp
  import cache_maint_pkg::*;
#(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned LINE_W  = 256,
  parameter int unsigned STALL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [IDX_W-1:0]   opIndex,
  input  logic [LINE_W-1:0]  opLine,
  output logic               cntZero,
  output logic               done,
  output logic [STALL_W-1:0] stallCount,
  output logic               invEn,
  output logic [IDX_W-1:0]   invIndex,
  output logic               wbPush,
  output logic [IDX_W-1:0]   wbAddr,
  output logic [LINE_W-1:0]  wbData
);

  localparam logic [STALL_W-1:0] STALL_MAX = {STALL_W{1'b1}};

  logic [IDX_W-1:0]   indexQ;
  logic [LINE_W-1:0]  lineQ;
  logic [CNT_W-1:0]   cntQ;
  logic [STALL_W-1:0] stallQ;
  logic               doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ <= '0;
      lineQ  <= '0;
    end else if (strobe.capture) begin
      indexQ <= opIndex;
      lineQ  <= opLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.cntLoad) begin
      cntQ <= strobe.cntInit;
    end else if (strobe.cntDec) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallQ <= '0;
    end else if (strobe.stallClr) begin
      stallQ <= '0;
    end else if (strobe.stallInc && (stallQ != STALL_MAX)) begin
      stallQ <= stallQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= strobe.finish;
  end

  assign cntZero    = (cntQ == '0);
  assign done       = doneQ;
  assign stallCount = stallQ;
  assign invEn      = strobe.inv;
  assign invIndex   = indexQ;
  assign wbPush     = strobe.push;
  assign wbAddr     = indexQ;
  assign wbData     = lineQ;

endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import cache_maint_pkg::*;
#(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned STALL_W    = 8,
  localparam int unsigned LINE_W    = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic               opCode,
  input  logic [1:0]         lookup,
  input  logic [IDX_W-1:0]   opIndex,
  input  logic [LINE_W-1:0]  opLine,
  input  logic               wbFull,
  output logic               busy,
  output logic               done,
  output logic [STALL_W-1:0] stallCount,
  output logic               invEn,
  output logic [IDX_W-1:0]   invIndex,
  output logic               wbPush,
  output logic [IDX_W-1:0]   wbAddr,
  output logic [LINE_W-1:0]  wbData
);

  seqStrobe_t strobe;
  logic       cntZero;

  cache_maint_ctl ctl (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .opCode  (opCode),
    .lookup  (lookup),
    .wbFull  (wbFull),
    .cntZero (cntZero),
    .strobe  (strobe),
    .busy    (busy)
  );

  cache_maint_dp #(
    .IDX_W   (IDX_W),
    .LINE_W  (LINE_W),
    .STALL_W (STALL_W)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opIndex    (opIndex),
    .opLine     (opLine),
    .cntZero    (cntZero),
    .done       (done),
    .stallCount (stallCount),
    .invEn      (invEn),
    .invIndex   (invIndex),
    .wbPush     (wbPush),
    .wbAddr     (wbAddr),
    .wbData     (wbData)
  );

endmodule

// File: rtl/cache_maint_seq_chk.sv
module cache_maint_seq_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic invEn,
  input logic wbPush,
  input logic wbFull
);

  AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    wbPush |-> !wbFull); // R5

  AST_PUSH_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    wbPush |-> invEn); // R4

  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wbPush |=> !wbPush); // R4

  AST_INV_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    invEn |=> !invEn); // R3

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(wbPush || invEn)); // R8

endmodule

bind cache_maint_seq cache_maint_seq_chk chk (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .done   (done),
  .invEn  (invEn),
  .wbPush (wbPush),
  .wbFull (wbFull)
);

// File: tb/cache_maint_seq_test.sv
`timescale 1ns/1ps
module cache_maint_seq_test;

  typedef struct {
    string        tag;
    int           stall;
    int           pushes;
    int           invs;
    logic [7:0]   idx;
    logic [255:0] line;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic         opCode = 1'b0;
  logic [1:0]   lookup = 2'b00;
  logic [7:0]   opIndex = '0;
  logic [255:0] opLine = '0;
  logic         wbFull;
  logic         busy, done, invEn, wbPush;
  logic [7:0]   stallCount, invIndex, wbAddr;
  logic [255:0] wbData;

  int  checks = 0;
  int  errors = 0;
  int  issued = 0;
  int  doneSeen = 0;
  int  drainLeft = 0;
  int  drainVal = 0;
  logic drainReq = 1'b0;
  bit  monOn = 1'b0;
  bit  finished = 1'b0;
  int  busyCnt = 0, pushCnt = 0, invCnt = 0;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  cache_maint_seq uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .lookup(lookup), .opIndex(opIndex), .opLine(opLine), .wbFull(wbFull),
    .busy(busy), .done(done), .stallCount(stallCount), .invEn(invEn),
    .invIndex(invIndex), .wbPush(wbPush), .wbAddr(wbAddr), .wbData(wbData)
  );

  // write-back buffer model: full for drainVal cycles after an operation is accepted
  always @(posedge clk) begin
    if (drainReq)           drainLeft <= drainVal;
    else if (drainLeft != 0) drainLeft <= drainLeft - 1;
  end
  assign wbFull = (drainLeft != 0);

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkLine(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s push data: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (busy) busyCnt++;
      if (wbPush) begin
        pushCnt++;
        check("R5", "push while full", int'(wbFull), 0);
        if (expQ.size() > 0) begin
          check(expQ[0].tag, "push index", int'(wbAddr), int'(expQ[0].idx));
          checkLine(expQ[0].tag, wbData, expQ[0].line);
        end
      end
      if (invEn) begin
        invCnt++;
        if (expQ.size() > 0)
          check(expQ[0].tag, "invalidate index", int'(invIndex), int'(expQ[0].idx));
      end
      if (done) begin
        doneSeen++;
        if (expQ.size() == 0) begin
          check("R9", "done without pending operation", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(e.tag, "stallCount (R10)", int'(stallCount), e.stall);
          check(e.tag, "busy cycles", busyCnt, e.stall);
          check(e.tag, "push count", pushCnt, e.pushes);
          check(e.tag, "invalidate count", invCnt, e.invs);
        end
        busyCnt = 0;
        pushCnt = 0;
        invCnt  = 0;
      end
    end
  end

  // driver: called at a negedge; waits until not busy, then issues one operation
  task automatic doOp(input string tag, input logic code, input logic [1:0] lk, input int n);
    expItem_t e;
    while (busy) @(negedge clk);
    issued++;
    e.tag  = tag;
    e.idx  = 8'(issued * 37 + 5);
    e.line = {8{16'(issued * 911), 8'hC3, e.idx}};
    if (lk == 2'b00)      begin e.stall = 0;     e.pushes = 0; e.invs = 0; end
    else if (code)        begin e.stall = 2;     e.pushes = 0; e.invs = 1; end
    else if (lk == 2'b01) begin e.stall = 3;     e.pushes = 0; e.invs = 1; end
    else                  begin e.stall = 3 + n; e.pushes = 1; e.invs = 1; end
    expQ.push_back(e);
    opCode   = code;
    lookup   = lk;
    opIndex  = e.idx;
    opLine   = e.line;
    opValid  = 1'b1;
    drainReq = 1'b1;
    drainVal = n;
    @(negedge clk);
    opValid  = 1'b0;
    drainReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "push", int'(wbPush), 0);
    check("R1", "invalidate", int'(invEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "stallCount", int'(stallCount), 0);
    check("R1", "busy after release", int'(busy), 0);
    monOn = 1'b1;

    doOp("R2", 1'b0, 2'b00, 0);   // write-back-invalidate, miss
    doOp("R3", 1'b0, 2'b01, 0);   // write-back-invalidate, clean hit
    doOp("R4", 1'b0, 2'b10, 0);   // dirty, buffer empty
    doOp("R5", 1'b0, 2'b10, 4);   // dirty, buffer full 4 cycles
    doOp("R5", 1'b0, 2'b10, 1);   // dirty, buffer full 1 cycle
    doOp("R6", 1'b1, 2'b00, 0);   // invalidate-only, miss
    doOp("R7", 1'b1, 2'b01, 0);   // invalidate-only, clean hit
    doOp("R7", 1'b1, 2'b10, 3);   // invalidate-only, dirty hit: no push
    doOp("R10", 1'b0, 2'b11, 2);  // lookup 11 treated as dirty

    // R8: requests during busy are ignored
    doOp("R8", 1'b0, 2'b01, 0);
    opValid = 1'b1;
    opCode  = 1'b0;
    lookup  = 2'b00;
    @(negedge clk);
    @(negedge clk);
    opValid = 1'b0;

    // R9: back-to-back operations accepted in the done cycle
    doOp("R9", 1'b0, 2'b00, 0);
    doOp("R9", 1'b1, 2'b00, 0);
    doOp("R9", 1'b1, 2'b11, 0);
    doOp("R9", 1'b0, 2'b00, 0);

    repeat (12) @(negedge clk);
    check("R9", "done pulses vs operations", doneSeen, issued);
    check("R8", "pending scoreboard entries", expQ.size(), 0);
    check("R9", "idle busy at end", int'(busy), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule